// File: doc/BRIEF.md
# Weighted Round Queue Arbiter

The arbiter decides which of up to eight output queues feeding a single port may send next. Each queue carries a 4-bit service code. Codes 0 to 8 are weights. Code 9 puts the queue in a strict-priority group. Every weight is turned into an 8-bit round mask whose set bits are spread across the eight rounds, so one queue's traffic does not arrive in bursts. A 3-bit round counter steps through the mask bit positions.

Queues in the strict-priority group always win over weighted queues. Within each round, weighted queues are served in ascending index order. A grant is issued as a registered one-hot vector together with its index, and it stays asserted until the consumer accepts it.

Configuration is written one queue at a time through a simple write port. Each write carries the queue index, the service code and a tail bit. The lowest-indexed queue whose tail bit is set closes the port's queue range.

Top module: `wrr_arb`

## Requirements
- R1: After reset the arbiter has no grant, `round_o` is 0 and `cfg_err_o` is 0.
- R2: Each weight code expands to a fixed round mask: 0→0x00, 1→0x01, 2→0x11, 3→0x49, 4→0x55, 5→0x57, 6→0x77, 7→0x7f, 8→0xff. When a weighted queue is the only queue requesting, it is granted in exactly the rounds whose mask bit is 1, visited in ascending round order with wrap-around.
- R3: A queue whose weight is 0 is never granted, even when it is non-empty.
- R4: With all queues continuously non-empty, each weighted queue receives one grant per set mask bit in each pass of eight rounds. With weights 8 and 1, 18 grants split 16 to 2.
- R5: Within round r, the eligible weighted queues are those with mask bit r set and a non-empty flag. They are granted in ascending index order, beginning after the last weighted queue granted. The round counter moves on only when none of them remains, and the next round's scan starts at queue 0.
- R6: A queue with code 9 is a strict-priority queue. If any such queue is non-empty, the lowest-indexed one is granted ahead of every weighted queue, and `round_o` does not change.
- R7: Queues above the lowest-indexed queue whose tail bit is set are never granted. If no tail bit is set, all queues take part.
- R8: A code of 10 to 15 raises `cfg_err_o` for an in-range queue, and that queue uses the mask 0xff.
- R9: `cfg_err_o` is raised when an in-range strict-priority queue sits above an in-range weighted queue.
- R10: `gnt_o` is one-hot exactly when `gnt_vld_o` is 1, and its set bit matches `gnt_idx_o`. A grant stays unchanged until `accept_i` is sampled high. When no queue is eligible, no grant is made.
- R11: Rewriting a weight while grants are flowing does not affect selection in the current round. The new mask is first used after the round counter next moves on, or after an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | 3 | Queue addressed by the write |
| cfg_code_i | input | 4 | Service code: 0-8 weight, 9 strict priority, 10-15 invalid |
| cfg_tail_i | input | 1 | Tail bit written with the code |
| ne_i | input | 8 | Per-queue non-empty flags |
| accept_i | input | 1 | Consumer takes the current grant |
| gnt_o | output | 8 | One-hot grant |
| gnt_idx_o | output | 3 | Index of the granted queue |
| gnt_vld_o | output | 1 | Grant valid |
| round_o | output | 3 | Round position of the most recent weighted grant |
| cfg_err_o | output | 1 | Configuration error |

## Verification
Every piece of arbitration state is visible at the ports. A wrong scan-start or round register shows up on the very next accepted grant as the wrong index or as a `round_o` value that jumps. A stale or early mask reload changes the grant sequence within two accepts of the rewrite. A corrupted expansion table changes the round sequence of a lone queue within eight grants. Grant hold is checked every cycle, because any change to the index while accept is low is visible immediately.

// File: rtl/wrr_pkg.sv
package wrr_pkg;
  localparam int unsigned NR = 8;            // rounds per pass, = mask width
  localparam int unsigned RW = $clog2(NR);
  localparam int unsigned CW = 4;
  localparam logic [CW-1:0] STAT_CODE = 4'd9;

  function automatic logic [NR-1:0] code_mask(input logic [CW-1:0] c);
    case (c)
      4'd0:    return 8'h00;
      4'd1:    return 8'h01;
      4'd2:    return 8'h11;
      4'd3:    return 8'h49;
      4'd4:    return 8'h55;
      4'd5:    return 8'h57;
      4'd6:    return 8'h77;
      4'd7:    return 8'h7f;
      default: return 8'hff;               // 8, static and invalid codes
    endcase
  endfunction
endpackage

// File: rtl/wrr_first.sv
module wrr_first #(
  parameter int unsigned N  = 8,
  parameter int unsigned QW = 3
) (
  input  logic [N-1:0]  req_i,
  output logic          fnd_o,
  output logic [QW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req_i[i]) idx_o = QW'(i);
  end
  assign fnd_o = |req_i;
endmodule

// File: rtl/wrr_cfg.sv
module wrr_cfg
  import wrr_pkg::*;
#(
  parameter int unsigned NQ = 8,
  parameter int unsigned QW = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [QW-1:0]          idx_i,
  input  logic [CW-1:0]          code_i,
  input  logic                   tail_i,
  input  logic                   reload_i,
  output logic [NQ-1:0][NR-1:0]  live_o,
  output logic [NQ-1:0]          stat_o,
  output logic [NQ-1:0]          act_o,
  output logic                   err_o
);
  logic [NQ-1:0][CW-1:0] code_q;
  logic [NQ-1:0]         tail_q;
  logic [NQ-1:0][NR-1:0] live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      tail_q <= '0;
      live_q <= '0;
    end else begin
      if (we_i && (int'(idx_i) < NQ)) begin
        code_q[idx_i] <= code_i;
        tail_q[idx_i] <= tail_i;
      end
      // live masks follow stored codes only at round boundaries / idle
      if (reload_i)
        for (int i = 0; i < NQ; i++) live_q[i] <= code_mask(code_q[i]);
    end
  end

  assign live_o = live_q;

  always_comb begin
    logic closed, wt_seen;
    closed  = 1'b0;
    wt_seen = 1'b0;
    err_o   = 1'b0;
    for (int i = 0; i < NQ; i++) begin
      stat_o[i] = (code_q[i] == STAT_CODE);
      act_o[i]  = !closed;
      closed    = closed | tail_q[i];
      if (act_o[i]) begin
        if (code_q[i] > STAT_CODE) err_o = 1'b1;
        if (stat_o[i] && wt_seen)  err_o = 1'b1;
        if (!stat_o[i])            wt_seen = 1'b1;
      end
    end
  end
endmodule

// File: rtl/wrr_arb.sv
module wrr_arb
  import wrr_pkg::*;
#(
  parameter int unsigned NQ = 8,
  localparam int unsigned QW = $clog2(NQ)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [QW-1:0] cfg_idx_i,
  input  logic [CW-1:0] cfg_code_i,
  input  logic          cfg_tail_i,
  input  logic [NQ-1:0] ne_i,
  input  logic          accept_i,
  output logic [NQ-1:0] gnt_o,
  output logic [QW-1:0] gnt_idx_o,
  output logic          gnt_vld_o,
  output logic [RW-1:0] round_o,
  output logic          cfg_err_o
);
  localparam int unsigned SW = QW + 1;          // scan start 0..NQ
  localparam int unsigned KW = $clog2(NR + 1);  // round lookahead 0..NR

  logic [NQ-1:0][NR-1:0] live;
  logic [NQ-1:0]         stat, act, st_req, wt_base;
  logic                  reload, upd;
  logic                  vld_q;
  logic [QW-1:0]         idx_q;
  logic [RW-1:0]         round_q;
  logic [SW-1:0]         st_q;

  wrr_cfg #(.NQ(NQ), .QW(QW)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .idx_i   (cfg_idx_i),
    .code_i  (cfg_code_i),
    .tail_i  (cfg_tail_i),
    .reload_i(reload),
    .live_o  (live),
    .stat_o  (stat),
    .act_o   (act),
    .err_o   (cfg_err_o)
  );

  assign st_req  = ne_i & act & stat;
  assign wt_base = ne_i & act & ~stat;

  logic          st_fnd;
  logic [QW-1:0] st_idx;
  wrr_first #(.N(NQ), .QW(QW)) u_st (.req_i(st_req), .fnd_o(st_fnd), .idx_o(st_idx));

  // k = 0: rest of current round; k = 1..NR-1: later rounds; k = NR: same round again from 0
  logic [NR:0]   k_fnd;
  logic [QW-1:0] k_idx [NR+1];

  for (genvar k = 0; k <= NR; k++) begin : g_look
    logic [RW-1:0] rk;
    logic [NQ-1:0] elig;
    assign rk = round_q + RW'(k);
    always_comb
      for (int i = 0; i < NQ; i++)
        elig[i] = wt_base[i] & live[i][rk] & ((k != 0) || (SW'(i) >= st_q));
    wrr_first #(.N(NQ), .QW(QW)) u_pk (.req_i(elig), .fnd_o(k_fnd[k]), .idx_o(k_idx[k]));
  end

  logic          wt_any;
  logic [KW-1:0] ksel;
  logic [QW-1:0] wt_idx;
  always_comb begin
    wt_any = 1'b0;
    ksel   = '0;
    wt_idx = '0;
    for (int k = NR; k >= 0; k--)
      if (k_fnd[k]) begin
        wt_any = 1'b1;
        ksel   = KW'(k);
        wt_idx = k_idx[k];
      end
  end

  assign upd    = !vld_q || accept_i;
  assign reload = upd && !st_fnd && (!wt_any || (ksel != '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= 1'b0;
      idx_q   <= '0;
      round_q <= '0;
      st_q    <= '0;
    end else if (upd) begin
      if (st_fnd) begin
        vld_q <= 1'b1;
        idx_q <= st_idx;
      end else if (wt_any) begin
        vld_q   <= 1'b1;
        idx_q   <= wt_idx;
        round_q <= round_q + ksel[RW-1:0];
        st_q    <= SW'(wt_idx) + SW'(1);
      end else begin
        vld_q <= 1'b0;
      end
    end
  end

  always_comb begin
    gnt_o = '0;
    if (vld_q) gnt_o[idx_q] = 1'b1;
  end
  assign gnt_idx_o = idx_q;
  assign gnt_vld_o = vld_q;
  assign round_o   = round_q;
endmodule

// File: rtl/wrr_arb_chk.sv
module wrr_arb_chk #(
  parameter int unsigned NQ = 8,
  parameter int unsigned QW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          accept_i,
  input logic [NQ-1:0] gnt_o,
  input logic [QW-1:0] gnt_idx_o,
  input logic          gnt_vld_o,
  input logic [2:0]    round_o,
  input logic [NQ-1:0] stat_i,
  input logic [NQ-1:0] act_i
);
  logic [NQ-1:0] act_d;
  logic          take_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_d  <= '0;
      take_d <= 1'b0;
    end else begin
      act_d  <= act_i;
      take_d <= !gnt_vld_o || accept_i;
    end
  end

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_vld_o && !accept_i |=> gnt_vld_o && $stable(gnt_idx_o));

  a_r10_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o) && (gnt_vld_o == (gnt_o != '0)));

  a_r10_idx_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_vld_o |-> gnt_o[gnt_idx_o]);

  a_r7_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_d && gnt_vld_o |-> act_d[gnt_idx_o]);

  // R6 / R5: round moves only alongside a fresh weighted grant
  a_r6_round_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(round_o) |-> gnt_vld_o && !stat_i[gnt_idx_o]);
endmodule

bind wrr_arb wrr_arb_chk #(.NQ(NQ), .QW(QW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .accept_i (accept_i),
  .gnt_o    (gnt_o),
  .gnt_idx_o(gnt_idx_o),
  .gnt_vld_o(gnt_vld_o),
  .round_o  (round_o),
  .stat_i   (stat),
  .act_i    (act)
);

// File: tb/tb_wrr_arb.sv
module tb_wrr_arb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [2:0] cfg_idx;
  logic [3:0] cfg_code;
  logic       cfg_tail;
  logic [7:0] ne;
  logic       accept;
  logic [7:0] gnt;
  logic [2:0] gnt_idx;
  logic       gnt_vld;
  logic [2:0] round;
  logic       cfg_err;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  wrr_arb dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx),
    .cfg_code_i(cfg_code), .cfg_tail_i(cfg_tail), .ne_i(ne), .accept_i(accept),
    .gnt_o(gnt), .gnt_idx_o(gnt_idx), .gnt_vld_o(gnt_vld), .round_o(round),
    .cfg_err_o(cfg_err)
  );

  task automatic chk_eq(string tag, int act_v, int exp_v);
    total++;
    if (act_v != exp_v) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
    end
  endtask

  function automatic logic [7:0] mask_of(int c);
    case (c)
      0: return 8'h00;  1: return 8'h01;  2: return 8'h11;
      3: return 8'h49;  4: return 8'h55;  5: return 8'h57;
      6: return 8'h77;  7: return 8'h7f;  default: return 8'hff;
    endcase
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_code = '0;
    cfg_tail = 1'b0; ne = '0; accept = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfg(int q, int code, bit tail);
    cfg_we = 1'b1; cfg_idx = 3'(q); cfg_code = 4'(code); cfg_tail = tail;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_vld();
    for (int n = 0; n < 20 && !gnt_vld; n++) @(negedge clk);
  endtask

  task automatic take(int exp_q, int exp_r, string tag);
    wait_vld();
    chk_eq({tag, " idx"}, gnt_vld ? int'(gnt_idx) : -1, exp_q);
    chk_eq({tag, " round"}, int'(round), exp_r);
    accept = 1'b1;
    @(negedge clk);
    accept = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk_eq("R1 vld", int'(gnt_vld), 0);
    chk_eq("R1 gnt", int'(gnt), 0);
    chk_eq("R1 round", int'(round), 0);
    chk_eq("R1 err", int'(cfg_err), 0);
  endtask

  task automatic t_lone(int code);
    logic [7:0] m;
    int r;
    int seen;
    do_reset();
    cfg(0, code, 1'b1);
    repeat (2) @(negedge clk);
    chk_eq($sformatf("R8 err code %0d", code), int'(cfg_err), code > 9 ? 1 : 0);
    m = mask_of(code);
    ne = 8'h01;
    if (m == 8'h00) begin
      seen = 0;
      repeat (10) begin @(negedge clk); if (gnt_vld) seen++; end
      chk_eq("R3 weight0 grants", seen, 0);
    end else begin
      r = 0;
      for (int g = 0; g < 8; g++) begin
        while (!m[r]) r = (r + 1) % 8;
        take(0, r, $sformatf("R2 code %0d grant %0d", code, g));
        r = (r + 1) % 8;
      end
    end
    ne = '0;
  endtask

  task automatic t_share();
    int cnt [3];
    cnt = '{0, 0, 0};
    do_reset();
    cfg(0, 8, 1'b0); cfg(1, 1, 1'b1); cfg(2, 8, 1'b0);
    repeat (2) @(negedge clk);
    ne = 8'hff;
    for (int g = 0; g < 18; g++) begin
      wait_vld();
      if (gnt_idx < 3) cnt[gnt_idx]++;
      accept = 1'b1; @(negedge clk); accept = 1'b0;
    end
    chk_eq("R4 q0 share", cnt[0], 16);
    chk_eq("R4 q1 share", cnt[1], 2);
    chk_eq("R7 q2 beyond tail", cnt[2], 0);
    ne = '0;
  endtask

  task automatic t_order();
    do_reset();
    cfg(0, 8, 1'b0); cfg(1, 8, 1'b0); cfg(2, 8, 1'b1);
    repeat (2) @(negedge clk);
    ne = 8'h07;
    take(0, 0, "R5 a"); take(1, 0, "R5 b"); take(2, 0, "R5 c");
    take(0, 1, "R5 d"); take(1, 1, "R5 e");
    ne = '0;
  endtask

  task automatic t_static();
    do_reset();
    cfg(0, 9, 1'b0); cfg(1, 9, 1'b0); cfg(2, 8, 1'b1);
    repeat (2) @(negedge clk);
    chk_eq("R9 legal static err", int'(cfg_err), 0);
    ne = 8'h04;
    take(2, 0, "R6 w0");
    ne = 8'h07;
    take(2, 1, "R6 w1");
    take(0, 1, "R6 s0");
    ne = 8'h06;
    take(0, 1, "R6 s0b");
    ne = 8'h04;
    take(1, 1, "R6 s1");
    take(2, 2, "R6 w2");
    ne = '0;
  endtask

  task automatic t_hold();
    do_reset();
    cfg(0, 8, 1'b0); cfg(1, 8, 1'b1);
    repeat (2) @(negedge clk);
    ne = 8'h03;
    @(negedge clk);
    for (int c = 0; c < 5; c++) begin
      ne = (c % 2) ? 8'h02 : 8'h00;
      @(negedge clk);
      chk_eq($sformatf("R10 hold gnt c%0d", c), int'(gnt), 1);
    end
    ne = '0;
    accept = 1'b1; @(negedge clk); accept = 1'b0;
    chk_eq("R10 idle no grant", int'(gnt_vld), 0);
  endtask

  task automatic t_tail();
    do_reset();
    cfg(7, 8, 1'b0);
    repeat (2) @(negedge clk);
    ne = 8'h80;
    take(7, 0, "R7 no tail");
    ne = '0;
    do_reset();
    cfg(3, 0, 1'b1); cfg(7, 8, 1'b0);
    repeat (2) @(negedge clk);
    ne = 8'h80;
    repeat (6) @(negedge clk);
    chk_eq("R7 above tail", int'(gnt_vld), 0);
    ne = '0;
  endtask

  task automatic t_err();
    do_reset();
    cfg(0, 4, 1'b0); cfg(1, 9, 1'b1);
    @(negedge clk);
    chk_eq("R9 static after weighted", int'(cfg_err), 1);
    cfg(1, 4, 1'b1); cfg(2, 9, 1'b0);
    @(negedge clk);
    chk_eq("R9 out of range ignored", int'(cfg_err), 0);
    cfg(0, 13, 1'b0);
    @(negedge clk);
    chk_eq("R8 bad code", int'(cfg_err), 1);
  endtask

  task automatic t_reload();
    do_reset();
    cfg(0, 8, 1'b0); cfg(1, 8, 1'b1);
    repeat (2) @(negedge clk);
    ne = 8'h03;
    wait_vld();
    cfg(1, 0, 1'b1);
    @(negedge clk);
    take(0, 0, "R11 a");
    take(1, 0, "R11 old mask");
    take(0, 1, "R11 c");
    take(0, 2, "R11 new mask");
    ne = '0;
  endtask

  initial begin
    t_reset();
    for (int c = 0; c <= 8; c++) t_lone(c);
    t_lone(12);
    t_share();
    t_order();
    t_static();
    t_hold();
    t_tail();
    t_err();
    t_reload();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule